// File: doc/BRIEF.md
# Bus Protocol Rule Monitor

This block sits beside a shared high-performance on-chip bus and observes it without driving anything. On every clock it evaluates a set of transfer, response and wait-state rules against the address-phase signals, the response signals and a small amount of history. Each rule owns a single bit of a wide error vector, so several violations that happen in the same cycle all show at once. When any bit is raised, the monitor also reports the identity of the current bus owner and the slave that is in the data phase.

A small word-addressed register port configures the monitor. Software can turn the whole monitor on or off, silence individual rules and set how many consecutive wait cycles are tolerated. A sticky summary records every rule that has fired since reset or since it was last cleared. It keeps no timing information, so a long run can be reviewed at a glance. Error-vector positions past the implemented rules are reserved and always read as zero.

Top module: `ahb_rule_monitor`

## Requirements
- R1: While `rst` is high the error vector, `mst_id_o` and `slv_id_o` are zero. After reset the control word (address 0) reads 0, the wait-limit word (address 1) reads `DEF_WAIT`, and all mask and summary words read 0. Error bits at positions 9 and above are always zero.
- R2: Bit 0 (hold) is raised when the previous cycle had `hready` low, an active transfer (`htrans` NONSEQ=2 or SEQ=3) and an OKAY response, and the current `haddr`, `htrans`, `hwrite`, `hsize` or `hburst` differs from its previous value.
- R3: Bit 1 is raised when `htrans` is SEQ (3) or BUSY (1) and the previous cycle's `htrans` was IDLE (0). The value of `htrans` before the first cycle after reset counts as IDLE.
- R4: A non-OKAY response (ERROR=1, RETRY=2, SPLIT=3) must span two cycles. Bit 2 is raised for a non-OKAY response with `hready` high when no pair is open. Bit 3 is raised when the cycle after an opening cycle (non-OKAY with `hready` low) does not repeat the same response with `hready` high.
- R5: Bit 4 is raised when the response is not OKAY (code 0) while the transfer in its data phase is IDLE or BUSY. The data-phase transfer is the `htrans` captured on the last cycle with `hready` high, and it is IDLE after reset.
- R6: Bit 5 is raised on a cycle with `hready` low when the number of directly preceding `hready`-low cycles is at least the programmed wait limit.
- R7: Bit 6 is raised whenever more than one `hsel` line is high.
- R8: For an active transfer, bit 7 is raised when `hsize` exceeds log2(`DATA_W`/8). Bit 8 is raised when `haddr` is not a multiple of 2^`hsize`.
- R9: Writing a one to a mask bit (mask words at addresses 2, 3 and 4 hold error bits 0-31, 32-63 and 64-72) keeps that error bit at zero from the next cycle on.
- R10: Control word bit 0 enables the monitor. While it is 0, no error bit is raised and the summary does not change.
- R11: When any error bit is high, `mst_id_o` equals `hmaster` and `slv_id_o` is the index of the lowest high `hsel` line captured on the last `hready`-high cycle. When no error bit is high, both are zero.
- R12: Summary words at addresses 5, 6 and 7 collect every error bit that has been raised. Writing ones to a summary word clears those bits, and an error raised in the same cycle as the clear wins.
- R13: Register reads return data one cycle after the address is presented. Writes take effect at the clock edge. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| hsel | input | NUM_SLV | Slave select lines |
| haddr | input | ADDR_W | Transfer address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | Transfer direction |
| hsize | input | 3 | Transfer size code |
| hburst | input | 3 | Burst type |
| hready | input | 1 | Transfer done / wait state when low |
| hresp | input | 2 | Slave response code |
| hmaster | input | MST_W | Current bus owner number |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| err_o | output | ERR_W | One bit per rule, combinational |
| mst_id_o | output | MST_W | Owner number tied to a flagged error |
| slv_id_o | output | SLV_W | Data-phase slave index tied to a flagged error |

## Verification
The bench builds the monitor with a reset wait limit of 4 and otherwise default sizes: 73 error bits in three register words, four slaves and a 32-bit data bus. The small limit lets the wait-timeout rule trigger within a handful of cycles, both from reset and after the limit is reprogrammed to 2 or 3. The 32-bit data bus makes the size rule reachable with `hsize` of 3. The four select lines allow multi-hot selects and non-zero slave indices, and the 73-bit vector puts a partial third word in both the mask and the summary.

// File: rtl/ahb_mon_pkg.sv
package ahb_mon_pkg;
  localparam logic [1:0] TR_IDLE   = 2'd0;
  localparam logic [1:0] TR_BUSY   = 2'd1;
  localparam logic [1:0] TR_NONSEQ = 2'd2;
  localparam logic [1:0] TR_SEQ    = 2'd3;

  localparam logic [1:0] RS_OKAY  = 2'd0;
  localparam logic [1:0] RS_ERROR = 2'd1;

  localparam int RULE_HOLD        = 0;
  localparam int RULE_AFTER_IDLE  = 1;
  localparam int RULE_RESP_FIRST  = 2;
  localparam int RULE_RESP_SECOND = 3;
  localparam int RULE_IDLE_OKAY   = 4;
  localparam int RULE_WAIT        = 5;
  localparam int RULE_MULTI_SEL   = 6;
  localparam int RULE_SIZE        = 7;
  localparam int RULE_ALIGN       = 8;
  localparam int NUM_RULES        = 9;

  function automatic logic is_active(input logic [1:0] t);
    return t[1];
  endfunction
endpackage

// File: rtl/ahb_sel_encoder.sv
module ahb_sel_encoder #(
  parameter int N = 4,
  parameter int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] sel_i,
  output logic [W-1:0] idx_o,
  output logic         multi_o
);
  generate
    if (N == 1) begin : g_single
      assign idx_o   = '0;
      assign multi_o = 1'b0;
    end else begin : g_multi
      always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
          if (sel_i[i]) idx_o = W'(i);
        end
      end
      assign multi_o = (sel_i & (sel_i - N'(1))) != '0;
    end
  endgenerate
endmodule

// File: rtl/ahb_rule_engine.sv
module ahb_rule_engine
  import ahb_mon_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int NUM_SLV = 4,
  parameter int WAIT_W  = 16,
  parameter int SLV_W   = (NUM_SLV > 1) ? $clog2(NUM_SLV) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SLV-1:0]   hsel,
  input  logic [ADDR_W-1:0]    haddr,
  input  logic [1:0]           htrans,
  input  logic                 hwrite,
  input  logic [2:0]           hsize,
  input  logic [2:0]           hburst,
  input  logic                 hready,
  input  logic [1:0]           hresp,
  input  logic [WAIT_W-1:0]    max_wait,
  output logic [NUM_RULES-1:0] raw_o,
  output logic [SLV_W-1:0]     dp_slv_o
);
  localparam int          MAX_SIZE = $clog2(DATA_W / 8);
  localparam logic [WAIT_W-1:0] CNT_TOP = '1;

  logic [ADDR_W-1:0] p_addr;
  logic [1:0]        p_trans, p_resp, dp_trans;
  logic              p_write, p_ready, pair_open, past_valid;
  logic [2:0]        p_size, p_burst;
  logic [WAIT_W-1:0] wait_cnt;
  logic [SLV_W-1:0]  sel_idx;
  logic              sel_multi;
  logic [7:0]        align_mask;
  logic              ctrl_moved, hold_armed, not_okay;

  ahb_sel_encoder #(.N(NUM_SLV), .W(SLV_W)) u_enc (
    .sel_i  (hsel),
    .idx_o  (sel_idx),
    .multi_o(sel_multi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      p_addr     <= '0;
      p_trans    <= TR_IDLE;
      p_write    <= 1'b0;
      p_size     <= '0;
      p_burst    <= '0;
      p_ready    <= 1'b1;
      p_resp     <= RS_OKAY;
      pair_open  <= 1'b0;
      dp_trans   <= TR_IDLE;
      dp_slv_o   <= '0;
      wait_cnt   <= '0;
      past_valid <= 1'b0;
    end else begin
      p_addr     <= haddr;
      p_trans    <= htrans;
      p_write    <= hwrite;
      p_size     <= hsize;
      p_burst    <= hburst;
      p_ready    <= hready;
      p_resp     <= hresp;
      pair_open  <= (hresp != RS_OKAY) && !hready && !pair_open;
      past_valid <= 1'b1;
      if (hready) begin
        dp_trans <= htrans;
        dp_slv_o <= sel_idx;
      end
      if (hready) wait_cnt <= '0;
      else if (wait_cnt != CNT_TOP) wait_cnt <= wait_cnt + WAIT_W'(1);
    end
  end

  assign not_okay   = hresp != RS_OKAY;
  assign hold_armed = !p_ready && is_active(p_trans) && (p_resp == RS_OKAY);
  assign ctrl_moved = (haddr != p_addr) || (htrans != p_trans) || (hwrite != p_write)
                    || (hsize != p_size) || (hburst != p_burst);
  assign align_mask = (8'd1 << hsize) - 8'd1;

  always_comb begin
    raw_o                   = '0;
    raw_o[RULE_HOLD]        = hold_armed && ctrl_moved;
    raw_o[RULE_AFTER_IDLE]  = (p_trans == TR_IDLE) && ((htrans == TR_SEQ) || (htrans == TR_BUSY));
    raw_o[RULE_RESP_FIRST]  = not_okay && hready && !pair_open;
    raw_o[RULE_RESP_SECOND] = pair_open && (!hready || (hresp != p_resp));
    raw_o[RULE_IDLE_OKAY]   = !is_active(dp_trans) && not_okay;
    raw_o[RULE_WAIT]        = !hready && (wait_cnt >= max_wait);
    raw_o[RULE_MULTI_SEL]   = sel_multi;
    raw_o[RULE_SIZE]        = is_active(htrans) && (int'(hsize) > MAX_SIZE);
    raw_o[RULE_ALIGN]       = is_active(htrans) && ((haddr[7:0] & align_mask) != 8'd0);
  end

  // R6
  wait_first_low_chk: assert property (@(posedge clk) disable iff (rst)
    (past_valid && raw_o[RULE_WAIT] && $past(hready)) |-> (max_wait == '0));

  // R4
  resp_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (past_valid && raw_o[RULE_RESP_SECOND]) |-> ($past(hresp) != RS_OKAY && !$past(hready)));
endmodule

// File: rtl/ahb_chk_regs.sv
module ahb_chk_regs #(
  parameter int ERR_W    = 73,
  parameter int WAIT_W   = 16,
  parameter int DEF_WAIT = 16,
  parameter int RA_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [ERR_W-1:0]  err_i,
  output logic [31:0]       reg_rdata,
  output logic              en_o,
  output logic [ERR_W-1:0]  mask_o,
  output logic [WAIT_W-1:0] max_wait_o
);
  localparam int NW        = (ERR_W + 31) / 32;
  localparam int PAD       = NW * 32;
  localparam int CTRL_ADDR = 0;
  localparam int WAIT_ADDR = 1;
  localparam int MASK_BASE = 2;
  localparam int SUM_BASE  = MASK_BASE + NW;
  localparam logic [PAD-1:0] VALID = ({{(PAD-1){1'b0}}, 1'b1} << ERR_W) - PAD'(1);

  logic [PAD-1:0] mask_q, sum_q, err_pad, mask_wr, mask_nx, sum_clr;
  logic [31:0]    rd_mux;
  logic           past_valid;

  assign err_pad = PAD'(err_i);

  generate
    for (genvar w = 0; w < NW; w++) begin : g_word
      logic hit_mask, hit_sum;
      assign hit_mask = reg_we && (reg_addr == RA_W'(MASK_BASE + w));
      assign hit_sum  = reg_we && (reg_addr == RA_W'(SUM_BASE + w));
      assign mask_wr[w*32 +: 32] = {32{hit_mask}};
      assign mask_nx[w*32 +: 32] = reg_wdata & VALID[w*32 +: 32];
      assign sum_clr[w*32 +: 32] = hit_sum ? reg_wdata : 32'd0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o       <= 1'b0;
      max_wait_o <= WAIT_W'(DEF_WAIT);
      mask_q     <= '0;
      sum_q      <= '0;
      past_valid <= 1'b0;
    end else begin
      past_valid <= 1'b1;
      if (reg_we && reg_addr == RA_W'(CTRL_ADDR)) en_o <= reg_wdata[0];
      if (reg_we && reg_addr == RA_W'(WAIT_ADDR)) max_wait_o <= reg_wdata[WAIT_W-1:0];
      mask_q <= (mask_q & ~mask_wr) | (mask_nx & mask_wr);
      sum_q  <= ((sum_q & ~sum_clr) | err_pad) & VALID;
    end
  end

  assign mask_o = mask_q[ERR_W-1:0];

  always_comb begin
    rd_mux = 32'd0;
    if (reg_addr == RA_W'(CTRL_ADDR)) rd_mux = {31'd0, en_o};
    if (reg_addr == RA_W'(WAIT_ADDR)) rd_mux = 32'(max_wait_o);
    for (int w = 0; w < NW; w++) begin
      if (reg_addr == RA_W'(MASK_BASE + w)) rd_mux = mask_q[w*32 +: 32];
      if (reg_addr == RA_W'(SUM_BASE + w))  rd_mux = sum_q[w*32 +: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= 32'd0;
    else     reg_rdata <= rd_mux;
  end

  // R12
  summary_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (past_valid && !$past(reg_we)) |-> ((sum_q & $past(sum_q)) == $past(sum_q)));

  // R12
  err_recorded_chk: assert property (@(posedge clk) disable iff (rst)
    (|err_i) |=> ((sum_q[ERR_W-1:0] & $past(err_i)) == $past(err_i)));
endmodule

// File: rtl/ahb_rule_monitor.sv
module ahb_rule_monitor
  import ahb_mon_pkg::*;
#(
  parameter int ERR_W    = 73,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_SLV  = 4,
  parameter int MST_W    = 4,
  parameter int WAIT_W   = 16,
  parameter int DEF_WAIT = 16,
  parameter int RA_W     = 4,
  parameter int SLV_W    = (NUM_SLV > 1) ? $clog2(NUM_SLV) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SLV-1:0] hsel,
  input  logic [ADDR_W-1:0]  haddr,
  input  logic [1:0]         htrans,
  input  logic               hwrite,
  input  logic [2:0]         hsize,
  input  logic [2:0]         hburst,
  input  logic               hready,
  input  logic [1:0]         hresp,
  input  logic [MST_W-1:0]   hmaster,
  input  logic               reg_we,
  input  logic [RA_W-1:0]    reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic [ERR_W-1:0]   err_o,
  output logic [MST_W-1:0]   mst_id_o,
  output logic [SLV_W-1:0]   slv_id_o
);
  logic [NUM_RULES-1:0] raw;
  logic [ERR_W-1:0]     raw_full, mask;
  logic [WAIT_W-1:0]    max_wait;
  logic [SLV_W-1:0]     dp_slv;
  logic                 enable;

  ahb_rule_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SLV(NUM_SLV),
    .WAIT_W(WAIT_W), .SLV_W(SLV_W)
  ) u_engine (
    .clk(clk), .rst(rst), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hburst(hburst), .hready(hready),
    .hresp(hresp), .max_wait(max_wait), .raw_o(raw), .dp_slv_o(dp_slv)
  );

  ahb_chk_regs #(
    .ERR_W(ERR_W), .WAIT_W(WAIT_W), .DEF_WAIT(DEF_WAIT), .RA_W(RA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .err_i(err_o), .reg_rdata(reg_rdata),
    .en_o(enable), .mask_o(mask), .max_wait_o(max_wait)
  );

  assign raw_full = ERR_W'(raw);
  assign err_o    = (rst || !enable) ? '0 : (raw_full & ~mask);
  assign mst_id_o = (|err_o) ? hmaster : '0;
  assign slv_id_o = (|err_o) ? dp_slv : '0;

  // R10
  disable_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == RA_W'(0) && !reg_wdata[0]) |=> (err_o == '0));
endmodule

// File: tb/ahb_rule_monitor_test.sv
module ahb_rule_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int ERR_W = 73, ADDR_W = 32, NUM_SLV = 4, MST_W = 4, WAIT_W = 16;
  localparam int DEF_WAIT = 4, RA_W = 4, SLV_W = 2, NR = 9, NW = 3;

  logic clk = 0, rst = 1;
  logic [NUM_SLV-1:0] hsel;  logic [ADDR_W-1:0] haddr;
  logic [1:0] htrans, hresp; logic hwrite, hready;
  logic [2:0] hsize, hburst; logic [MST_W-1:0] hmaster;
  logic reg_we; logic [RA_W-1:0] reg_addr; logic [31:0] reg_wdata, reg_rdata;
  logic [ERR_W-1:0] err_o; logic [MST_W-1:0] mst_id_o; logic [SLV_W-1:0] slv_id_o;

  // next-cycle stimulus
  logic n_rst = 1; logic [NUM_SLV-1:0] n_sel = 4'b0001; logic [ADDR_W-1:0] n_addr = 0;
  logic [1:0] n_trans = 0, n_resp = 0; logic n_write = 0, n_ready = 1;
  logic [2:0] n_size = 0, n_burst = 0; logic [MST_W-1:0] n_mst = 0;
  logic n_we = 0; logic [RA_W-1:0] n_raddr = 0; logic [31:0] n_wdata = 0;

  // reference state
  logic [ADDR_W-1:0] m_addr; logic [1:0] m_trans, m_resp, m_dptrans;
  logic m_write, m_ready, m_pair; logic [2:0] m_size, m_burst;
  logic [WAIT_W-1:0] m_wcnt; logic [SLV_W-1:0] m_dpslv;
  logic m_en; logic [WAIT_W-1:0] m_maxw; logic [95:0] m_mask, m_sum;
  logic [ERR_W-1:0] obs_err;

  int checks = 0, fails = 0; bit done = 0;

  ahb_rule_monitor #(.ERR_W(ERR_W), .ADDR_W(ADDR_W), .NUM_SLV(NUM_SLV), .MST_W(MST_W),
    .WAIT_W(WAIT_W), .DEF_WAIT(DEF_WAIT), .RA_W(RA_W)) uut (
    .clk(clk), .rst(rst), .hsel(hsel), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
    .hsize(hsize), .hburst(hburst), .hready(hready), .hresp(hresp), .hmaster(hmaster),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .err_o(err_o), .mst_id_o(mst_id_o), .slv_id_o(slv_id_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string tag_of(input int b);
    case (b)
      0: return "R2"; 1: return "R3"; 2, 3: return "R4"; 4: return "R5";
      5: return "R6"; 6: return "R7"; 7, 8: return "R8"; default: return "R1";
    endcase
  endfunction

  function automatic logic [SLV_W-1:0] low_idx(input logic [NUM_SLV-1:0] s);
    for (int i = 0; i < NUM_SLV; i++) if (s[i]) return SLV_W'(i);
    return '0;
  endfunction

  function automatic logic [NR-1:0] ref_rules();
    logic [NR-1:0] r = '0;
    logic [7:0] am = (8'd1 << n_size) - 8'd1;
    r[0] = !m_ready && m_trans[1] && m_resp == 0 &&
           (n_addr != m_addr || n_trans != m_trans || n_write != m_write ||
            n_size != m_size || n_burst != m_burst);
    r[1] = m_trans == 0 && (n_trans == 3 || n_trans == 1);
    r[2] = n_resp != 0 && n_ready && !m_pair;
    r[3] = m_pair && (!n_ready || n_resp != m_resp);
    r[4] = !m_dptrans[1] && n_resp != 0;
    r[5] = !n_ready && m_wcnt >= m_maxw;
    r[6] = $countones(n_sel) > 1;
    r[7] = n_trans[1] && n_size > 3'd2;
    r[8] = n_trans[1] && (n_addr[7:0] & am) != 0;
    return r;
  endfunction

  function automatic logic [31:0] ref_read(input logic [RA_W-1:0] a);
    case (a)
      0: return {31'd0, m_en};
      1: return 32'(m_maxw);
      2, 3, 4: return m_mask[(int'(a) - 2) * 32 +: 32];
      5, 6, 7: return m_sum[(int'(a) - 5) * 32 +: 32];
      default: return 32'd0;
    endcase
  endfunction

  task automatic step();
    logic [ERR_W-1:0] exp_err; logic [MST_W-1:0] exp_m; logic [SLV_W-1:0] exp_s;
    logic [95:0] clr;
    @(negedge clk);
    rst = n_rst; hsel = n_sel; haddr = n_addr; htrans = n_trans; hwrite = n_write;
    hsize = n_size; hburst = n_burst; hready = n_ready; hresp = n_resp; hmaster = n_mst;
    reg_we = n_we; reg_addr = n_raddr; reg_wdata = n_wdata;
    #1;
    exp_err = '0;
    if (!n_rst && m_en) exp_err = ERR_W'(ref_rules()) & ~m_mask[ERR_W-1:0];
    exp_m = (|exp_err) ? n_mst : '0;
    exp_s = (|exp_err) ? m_dpslv : '0;
    obs_err = err_o;
    checks++;
    if (err_o !== exp_err) begin
      int b = 0;
      for (int i = ERR_W - 1; i >= 0; i--) if (err_o[i] !== exp_err[i]) b = i;
      fails++;
      $display("FAIL %s error vector actual=%h expected=%h", tag_of(b), err_o, exp_err);
    end
    checks++;
    if (mst_id_o !== exp_m || slv_id_o !== exp_s) begin
      fails++;
      $display("FAIL R11 ids actual=%0d/%0d expected=%0d/%0d", mst_id_o, slv_id_o, exp_m, exp_s);
    end
    if (n_rst) begin
      m_addr = 0; m_trans = 0; m_write = 0; m_size = 0; m_burst = 0; m_ready = 1;
      m_resp = 0; m_pair = 0; m_dptrans = 0; m_dpslv = 0; m_wcnt = 0;
      m_en = 0; m_maxw = WAIT_W'(DEF_WAIT); m_mask = 0; m_sum = 0;
    end else begin
      clr = 0;
      if (n_we && n_raddr >= 5 && n_raddr <= 7) clr[(int'(n_raddr) - 5) * 32 +: 32] = n_wdata;
      m_sum = (m_sum & ~clr) | 96'(exp_err);
      if (n_we && n_raddr == 0) m_en = n_wdata[0];
      if (n_we && n_raddr == 1) m_maxw = n_wdata[WAIT_W-1:0];
      if (n_we && n_raddr >= 2 && n_raddr <= 4)
        m_mask[(int'(n_raddr) - 2) * 32 +: 32] = n_wdata;
      m_mask[95:ERR_W] = '0;
      m_pair = n_resp != 0 && !n_ready && !m_pair;
      if (n_ready) begin m_dptrans = n_trans; m_dpslv = low_idx(n_sel); end
      if (n_ready) m_wcnt = 0; else if (m_wcnt != '1) m_wcnt = m_wcnt + 1;
      m_addr = n_addr; m_trans = n_trans; m_write = n_write; m_size = n_size;
      m_burst = n_burst; m_ready = n_ready; m_resp = n_resp;
    end
  endtask

  task automatic bus(input logic [1:0] t, input logic [ADDR_W-1:0] a, input logic [2:0] sz,
                     input logic rdy, input logic [1:0] rs);
    n_trans = t; n_addr = a; n_size = sz; n_ready = rdy; n_resp = rs;
    step();
  endtask

  task automatic idle();
    bus(0, 0, 0, 1, 0);
  endtask

  task automatic wr(input logic [RA_W-1:0] a, input logic [31:0] d);
    n_we = 1; n_raddr = a; n_wdata = d;
    step();
    n_we = 0;
  endtask

  task automatic rd(input logic [RA_W-1:0] a, input string tag);
    logic [31:0] e;
    n_raddr = a;
    e = ref_read(a);
    step();
    @(posedge clk); #1;
    checks++;
    if (reg_rdata !== e) begin
      fails++;
      $display("FAIL %s read addr %0d actual=%h expected=%h", tag, a, reg_rdata, e);
    end
  endtask

  task automatic chk_bit(input int b, input logic v, input string tag);
    checks++;
    if (obs_err[b] !== v) begin
      fails++;
      $display("FAIL %s bit %0d actual=%b expected=%b", tag, b, obs_err[b], v);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R1: reset holds outputs low even with a violating bus
    n_rst = 1; n_sel = 4'b0011;
    repeat (2) idle();
    bus(3, 1, 3, 0, 1);
    chk_bit(1, 0, "R1"); chk_bit(6, 0, "R1");
    n_rst = 0; n_sel = 4'b0100; n_mst = 4'd5;
    idle();
    for (int a = 0; a < 8; a++) rd(RA_W'(a), "R1");
    // R10: disabled monitor stays silent
    bus(3, 0, 0, 1, 0);
    chk_bit(1, 0, "R10");
    idle();
    wr(0, 1);
    rd(0, "R13");
    // R3, R11
    idle();
    bus(3, 0, 0, 1, 0);
    chk_bit(1, 1, "R3");
    checks++;
    if (mst_id_o !== 4'd5 || slv_id_o !== 2'd2) begin
      fails++;
      $display("FAIL R11 ids actual=%0d/%0d expected=5/2", mst_id_o, slv_id_o);
    end
    // R2: control change during wait
    bus(2, 32'h100, 2, 0, 0);
    bus(2, 32'h100, 2, 0, 0);
    chk_bit(0, 0, "R2");
    bus(2, 32'h104, 2, 1, 0);
    chk_bit(0, 1, "R2");
    // R4: legal pair, early high, broken second cycle
    bus(2, 32'h200, 2, 1, 0);
    bus(0, 0, 0, 0, 1);
    chk_bit(2, 0, "R4"); chk_bit(3, 0, "R4");
    bus(2, 32'h300, 2, 1, 1);
    chk_bit(3, 0, "R4");
    bus(2, 32'h300, 2, 1, 2);
    chk_bit(2, 1, "R4");
    bus(2, 32'h300, 2, 0, 1);
    bus(0, 0, 0, 1, 0);
    chk_bit(3, 1, "R4");
    // R5: non-OKAY in the data phase of an IDLE
    idle();
    bus(0, 0, 0, 0, 1);
    chk_bit(4, 1, "R5");
    bus(0, 0, 0, 1, 1);
    idle();
    // R6: wait limit of 2
    wr(1, 2);
    bus(0, 0, 0, 0, 0);
    bus(0, 0, 0, 0, 0);
    chk_bit(5, 0, "R6");
    bus(0, 0, 0, 0, 0);
    chk_bit(5, 1, "R6");
    idle();
    // R7, R8
    n_sel = 4'b0011; idle(); chk_bit(6, 1, "R7");
    n_sel = 4'b1000; bus(2, 0, 3, 1, 0); chk_bit(7, 1, "R8");
    bus(2, 32'h2, 2, 1, 0); chk_bit(8, 1, "R8"); chk_bit(7, 0, "R8");
    bus(2, 32'h4, 2, 1, 0); chk_bit(8, 0, "R8");
    idle();
    // R12: summary content and clearing
    rd(5, "R12");
    wr(5, 32'h2);
    rd(5, "R12");
    n_sel = 4'b0011; wr(5, 32'h40); n_sel = 4'b0001;
    rd(5, "R12");
    // R9: mask rule 1 and the top word
    wr(2, 32'h2); wr(4, 32'hFFFF_FFFF);
    rd(4, "R9");
    idle();
    bus(3, 0, 0, 1, 0);
    chk_bit(1, 0, "R9");
    // R13: unmapped address
    rd(9, "R13"); rd(1, "R13");
    // R10: disable freezes summary
    wr(0, 0);
    n_sel = 4'b0110; idle(); chk_bit(6, 0, "R10");
    rd(5, "R10");
    // random phase, checked cycle by cycle against the reference
    wr(0, 1); wr(1, 3); wr(2, 32'h0A0); wr(4, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r = 4'($urandom);
      n_trans = 2'($urandom);
      n_ready = ($urandom % 10) < 7;
      n_resp = (($urandom % 8) == 0) ? 2'($urandom) : 2'd0;
      n_size = ($urandom % 5 == 0) ? 3'($urandom) : 3'($urandom % 3);
      n_addr = (($urandom % 4) == 0) ? 32'($urandom) : (n_addr + 32'd4);
      n_write = 1'($urandom); n_burst = 3'($urandom); n_mst = 4'($urandom);
      n_sel = (r == 0) ? 4'($urandom) : (4'b0001 << (r % 4));
      n_we = ($urandom % 32) == 0; n_raddr = RA_W'(5); n_wdata = $urandom;
      step();
      n_we = 0;
    end
    idle();
    for (int a = 5; a < 8; a++) rd(RA_W'(a), "R12");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule